// File: doc/BRIEF.md
# Clock Output Enable and Power-Down Controller

This block decides, every system clock cycle, which of nine clock outputs may drive its pad. Five of the outputs are differential 100 MHz outputs and four are single-ended (two 50 MHz, one rate-selectable, one 32.256 MHz). The block also decides whether the PLL is powered down. Its inputs are three control register bytes, an asynchronous active-low power-down pin and the system clock. A disabled output has its pad driver placed in high impedance. The pad stage treats an enable of 0 as a request to tristate.

A global enable is layered over the individual enable bits. Bit 6 of control byte 0 picks the source of the global enable. When the bit is 0, the filtered pin is the source. When it is 1, bit 5 of control byte 0 is the source. The pin is synchronised to the system clock. A low level on it counts only after it has been held for a parameterised number of clock periods, so short glitches are rejected. All enables and the PLL power-down are issued from registers, so a register write cannot cause a glitch on them.

Top module: `clkoe_ctrl`

## Requirements
- R1: With byte 0 bit 6 = 0 and the pin held high, each output follows its own enable bit, pll_pd is 0, and byte 0 bit 5 has no effect.
- R2: With byte 0 bit 6 = 1 and byte 0 bit 5 = 0, every enable is 0 and pll_pd is 1, whatever the pin level.
- R3: With byte 0 bit 6 = 1 and byte 0 bit 5 = 1, each output follows its own enable bit and pll_pd is 0, whatever the pin level.
- R4: With byte 0 bit 6 = 0, a pin held low for at least FILT_CYCLES clock periods forces every enable to 0 and pll_pd to 1.
- R5: With byte 0 bit 6 = 0, a low pin pulse of fewer than FILT_CYCLES-1 clock periods changes no output and leaves pll_pd at 0.
- R6: Enable bit map: hcsl_oe[0..4] take byte 3 bits 1, 2, 4, 5, 7. se_oe[0] (50 MHz #1) takes byte 1 bit 6, se_oe[1] (50 MHz #2) takes byte 0 bit 0, se_oe[2] (selectable) takes byte 1 bit 5, and se_oe[3] (32.256 MHz) takes byte 1 bit 7. Every other register bit has no effect on the outputs.
- R7: pll_pd is 1 exactly when the global enable is false, and while pll_pd is 1 every enable is 0.
- R8: While rst_n is low, every enable is 0 and pll_pd is 1.
- R9: A register byte change applied between clock edges reaches the outputs at the next rising edge and not before it.
- R10: In hardware mode, after a filtered power-down the outputs are enabled again at the fourth rising edge after the pin returns high, and are still off after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| pd_pin_n | input | 1 | External power-down pin, active low, asynchronous |
| cfg0_i | input | 8 | Control byte 0 (mode, software enable, one output enable) |
| cfg1_i | input | 8 | Control byte 1 (three single-ended enables) |
| cfg3_i | input | 8 | Control byte 3 (differential output enables) |
| hcsl_oe | output | 5 | Enables of the five differential outputs |
| se_oe | output | 4 | Enables of the four single-ended outputs |
| pll_pd | output | 1 | PLL power-down, active high |

## Verification
The hardest condition to reach is the boundary of the glitch filter. The enable state must survive a low pulse just short of the threshold, and must fall after a pulse that is long enough. Both pulses have to be produced in hardware mode while the pin's synchroniser delay is hidden from the ports. Directed pulses of FILT_CYCLES-2 and FILT_CYCLES+6 periods are driven on the falling clock edge, and the outputs are sampled at every cycle during and after them. Randomised register bytes and pin levels are then settled and compared with a bench model. The randomised part also covers the cases where the software enable is ignored and where the pin is ignored.

// File: rtl/clkoe_pkg.sv
package clkoe_pkg;

    localparam int NUM_DIFF = 5;
    localparam int NUM_SE   = 4;
    localparam int NUM_OUT  = NUM_DIFF + NUM_SE;

    // control byte 0 fields
    localparam int B0_MODE_SW  = 6;
    localparam int B0_SW_EN    = 5;
    localparam int B0_SE50_TWO = 0;

    // control byte 1 fields
    localparam int B1_SE32     = 7;
    localparam int B1_SE50_ONE = 6;
    localparam int B1_SE_SEL   = 5;

    // source that currently governs the global enable
    typedef enum logic [1:0] {
        GSRC_PIN    = 2'd0,
        GSRC_SW_OFF = 2'd1,
        GSRC_SW_ON  = 2'd2
    } gsrc_e;

    // bit of control byte 3 that enables differential output idx
    function automatic int diff_bit(input int idx);
        case (idx)
            0:       return 1;
            1:       return 2;
            2:       return 4;
            3:       return 5;
            default: return 7;
        endcase
    endfunction

endpackage

// File: rtl/clkoe_pin_filter.sv
module clkoe_pin_filter #(
    parameter int FILT_CYCLES = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic pd_req
);

    localparam int CW = $clog2(FILT_CYCLES + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(FILT_CYCLES - 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [CW-1:0]          cnt;
        logic                   pd;
    } filt_st_t;

    filt_st_t st_d, st_q;
    logic     pin_s;

    assign pin_s = st_q.sync[SYNC_STAGES-1];

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], pin_n};
        if (pin_s) begin
            // pin released: the request drops at once
            st_d.cnt = '0;
            st_d.pd  = 1'b0;
        end else if (st_q.cnt == CNT_LAST) begin
            // FILT_CYCLES consecutive low samples seen
            st_d.pd  = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sync <= '1;
            st_q.cnt  <= '0;
            st_q.pd   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pd_req = st_q.pd;

endmodule

// File: rtl/clkoe_global_sel.sv
module clkoe_global_sel
    import clkoe_pkg::*;
(
    input  logic  mode_sw,
    input  logic  sw_en,
    input  logic  pd_req,
    output gsrc_e src,
    output logic  global_en
);

    always_comb begin
        if (!mode_sw)   src = GSRC_PIN;
        else if (sw_en) src = GSRC_SW_ON;
        else            src = GSRC_SW_OFF;

        case (src)
            GSRC_PIN:    global_en = !pd_req;
            GSRC_SW_ON:  global_en = 1'b1;
            default:     global_en = 1'b0;
        endcase
    end

endmodule

// File: rtl/clkoe_gate.sv
module clkoe_gate #(
    parameter int N = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         global_en,
    input  logic [N-1:0] en_bits,
    output logic [N-1:0] oe,
    output logic         pll_pd
);

    typedef struct packed {
        logic [N-1:0] oe;
        logic         pd;
    } gate_st_t;

    gate_st_t st_d, st_q;
    logic [N-1:0] oe_next;

    for (genvar g = 0; g < N; g++) begin : g_out
        assign oe_next[g] = global_en & en_bits[g];
    end

    always_comb begin
        st_d    = st_q;
        st_d.oe = oe_next;
        st_d.pd = !global_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.oe <= '0;
            st_q.pd <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign oe     = st_q.oe;
    assign pll_pd = st_q.pd;

endmodule

// File: rtl/clkoe_ctrl.sv
module clkoe_ctrl
    import clkoe_pkg::*;
#(
    parameter int FILT_CYCLES = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pd_pin_n,
    input  logic [7:0]          cfg0_i,
    input  logic [7:0]          cfg1_i,
    input  logic [7:0]          cfg3_i,
    output logic [NUM_DIFF-1:0] hcsl_oe,
    output logic [NUM_SE-1:0]   se_oe,
    output logic                pll_pd
);

    logic                pd_req;
    logic                global_en;
    gsrc_e               src;
    logic [NUM_DIFF-1:0] diff_bits;
    logic [NUM_SE-1:0]   se_bits;
    logic [NUM_OUT-1:0]  oe_all;
    logic                unused_cfg;

    clkoe_pin_filter #(
        .FILT_CYCLES (FILT_CYCLES),
        .SYNC_STAGES (SYNC_STAGES)
    ) i_filt (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_n  (pd_pin_n),
        .pd_req (pd_req)
    );

    clkoe_global_sel i_gsel (
        .mode_sw   (cfg0_i[B0_MODE_SW]),
        .sw_en     (cfg0_i[B0_SW_EN]),
        .pd_req    (pd_req),
        .src       (src),
        .global_en (global_en)
    );

    for (genvar g = 0; g < NUM_DIFF; g++) begin : g_diff
        assign diff_bits[g] = cfg3_i[diff_bit(g)];
    end

    assign se_bits[0] = cfg1_i[B1_SE50_ONE];
    assign se_bits[1] = cfg0_i[B0_SE50_TWO];
    assign se_bits[2] = cfg1_i[B1_SE_SEL];
    assign se_bits[3] = cfg1_i[B1_SE32];

    clkoe_gate #(
        .N (NUM_OUT)
    ) i_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .global_en (global_en),
        .en_bits   ({se_bits, diff_bits}),
        .oe        (oe_all),
        .pll_pd    (pll_pd)
    );

    assign hcsl_oe = oe_all[NUM_DIFF-1:0];
    assign se_oe   = oe_all[NUM_OUT-1:NUM_DIFF];

    assign unused_cfg = ^{cfg0_i[7], cfg0_i[4:1], cfg1_i[4:0],
                          cfg3_i[6], cfg3_i[3], cfg3_i[0], src};

endmodule

// File: rtl/clkoe_ctrl_chk.sv
module clkoe_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pd_pin_n,
    input logic [7:0] cfg0_i,
    input logic [7:0] cfg1_i,
    input logic [7:0] cfg3_i,
    input logic [4:0] hcsl_oe,
    input logic [3:0] se_oe,
    input logic       pll_pd
);

    // R2
    sw_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg0_i[6] && !cfg0_i[5]) |=> (pll_pd && hcsl_oe == '0 && se_oe == '0));

    // R3
    sw_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg0_i[6] && cfg0_i[5]) |=> (!pll_pd &&
            hcsl_oe == {$past(cfg3_i[7]), $past(cfg3_i[5]), $past(cfg3_i[4]),
                        $past(cfg3_i[2]), $past(cfg3_i[1])} &&
            se_oe == {$past(cfg1_i[7]), $past(cfg1_i[5]), $past(cfg0_i[0]),
                      $past(cfg1_i[6])}));

    // R7
    pd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pll_pd |-> (hcsl_oe == '0 && se_oe == '0));

    // R5
    filt_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pll_pd) && $past(!cfg0_i[6]) && $past(!cfg0_i[6], 2))
            |-> ($past(!pd_pin_n, 3) && $past(!pd_pin_n, 4)));

    // R9
    steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg0_i[6] && cfg0_i[5] && $stable(cfg0_i) && $stable(cfg1_i) && $stable(cfg3_i))
            |=> ($stable(hcsl_oe) && $stable(se_oe)));

endmodule

bind clkoe_ctrl clkoe_ctrl_chk i_chk (.*);

// File: tb/test_clkoe_ctrl.sv
module test_clkoe_ctrl;

    localparam int FILT = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pd_pin_n = 1'b1;
    logic [7:0] cfg0 = 8'h00;
    logic [7:0] cfg1 = 8'h00;
    logic [7:0] cfg3 = 8'h00;
    logic [4:0] hcsl_oe;
    logic [3:0] se_oe;
    logic       pll_pd;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    clkoe_ctrl #(.FILT_CYCLES(FILT)) i_clkoe_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .pd_pin_n (pd_pin_n),
        .cfg0_i   (cfg0),
        .cfg1_i   (cfg1),
        .cfg3_i   (cfg3),
        .hcsl_oe  (hcsl_oe),
        .se_oe    (se_oe),
        .pll_pd   (pll_pd)
    );

    // {pll_pd, se_oe[3:0], hcsl_oe[4:0]} from the requirements
    function automatic logic [9:0] model(input logic [7:0] b0, input logic [7:0] b1,
                                         input logic [7:0] b3, input logic pin_down);
        logic g;
        logic [4:0] d;
        logic [3:0] s;
        g = b0[6] ? b0[5] : !pin_down;
        d = {b3[7], b3[5], b3[4], b3[2], b3[1]};
        s = {b1[7], b1[5], b0[0], b1[6]};
        return {!g, g ? s : 4'h0, g ? d : 5'h0};
    endfunction

    function automatic logic [9:0] seen();
        return {pll_pd, se_oe, hcsl_oe};
    endfunction

    task automatic check(input string req, input logic [9:0] exp);
        n_chk++;
        if (seen() !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", req, seen(), exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got hung expected finish");
            summary();
        end
    end

    initial begin
        bit ok;
        void'($urandom(32'h5eed_c10c));

        // R8: reset state
        tick(3);
        check("R8", 10'b1_0000_00000);
        rst_n = 1'b1;

        // R1: hardware mode, pin high, software bit 0 ignored
        cfg0 = 8'b1000_0001;
        cfg1 = 8'hff;
        cfg3 = 8'hff;
        tick(4);
        check("R1", 10'b0_1111_11111);

        // R6: walk each enable bit in software-on mode, foreign bits set
        for (int i = 0; i < 9; i++) begin
            logic [9:0] e;
            cfg0 = 8'b1111_1110;
            cfg1 = 8'b0001_1111;
            cfg3 = 8'b0100_1001;
            case (i)
                0: cfg3[1] = 1'b1;
                1: cfg3[2] = 1'b1;
                2: cfg3[4] = 1'b1;
                3: cfg3[5] = 1'b1;
                4: cfg3[7] = 1'b1;
                5: cfg1[6] = 1'b1;
                6: cfg0[0] = 1'b1;
                7: cfg1[5] = 1'b1;
                default: cfg1[7] = 1'b1;
            endcase
            e = 10'b0;
            e[i] = 1'b1;
            tick(1);
            check("R6", e);
        end

        // R6: only foreign bits set gives all off with pll running
        cfg0 = 8'b1111_1110;
        cfg1 = 8'b0001_1111;
        cfg3 = 8'b0100_1001;
        tick(1);
        check("R6", 10'b0);

        // R9: change lands at the next edge and not before
        cfg3 = 8'hff;
        #1;
        check("R9", 10'b0);
        tick(1);
        check("R9", 10'b0_0000_11111);

        // R5: short glitch in hardware mode changes nothing
        cfg0 = 8'b0000_0001;
        cfg1 = 8'hff;
        cfg3 = 8'hff;
        tick(4);
        ok = 1'b1;
        pd_pin_n = 1'b0;
        for (int k = 0; k < FILT - 2; k++) begin
            tick(1);
            if (seen() !== 10'b0_1111_11111) ok = 1'b0;
        end
        pd_pin_n = 1'b1;
        for (int k = 0; k < FILT; k++) begin
            tick(1);
            if (seen() !== 10'b0_1111_11111) ok = 1'b0;
        end
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL R5: got %b expected %b", seen(), 10'b0_1111_11111);
        end

        // R4: long low pulse powers everything down
        pd_pin_n = 1'b0;
        tick(FILT + 6);
        check("R4", 10'b1_0000_00000);

        // R1: software bit set in hardware mode still ignored
        cfg0 = 8'b0010_0001;
        tick(2);
        check("R1", 10'b1_0000_00000);

        // R10: release timing
        pd_pin_n = 1'b1;
        tick(2);
        check("R10", 10'b1_0000_00000);
        tick(2);
        check("R10", 10'b0_1111_11111);

        // R3: software on with pin low
        pd_pin_n = 1'b0;
        cfg0 = 8'b0110_0001;
        tick(FILT + 6);
        check("R3", 10'b0_1111_11111);

        // R2: software off with pin high
        pd_pin_n = 1'b1;
        cfg0 = 8'b0100_0001;
        tick(6);
        check("R2", 10'b1_0000_00000);

        // R7: pll_pd tracks the global disable, randomised settled cases
        for (int it = 0; it < 150; it++) begin
            logic pin_dn;
            cfg0 = 8'($urandom);
            cfg1 = 8'($urandom);
            cfg3 = 8'($urandom);
            pin_dn = 1'($urandom);
            pd_pin_n = !pin_dn;
            tick(FILT + 6);
            check("R7", model(cfg0, cfg1, cfg3, pin_dn));
        end

        done = 1'b1;
        summary();
    end

endmodule